// File: doc/BRIEF.md
# Indirect-Access GPIO Port

This peripheral gives an 8-bit processor eleven general-purpose pins through only two bus locations. One location is an index register. The value written there chooses one internal register. The other location is a data window that reads or writes whichever internal register the index currently names. The index is not cleared by data accesses, so once it is set, software can poll or update one register many times without writing the index again.

The internal bank has a data register and a direction register for each of two pin groups. The narrow group is 3 pins wide and the wide group is 8 pins wide. A direction bit of 0 makes its pin an output, and a direction bit of 1 makes it an input. Output pins always show the stored data bit, and every pin has its own output-enable line. A data-register read returns a per-bit mix: input bits come from a two-stage synchronizer on the pin, and output bits come from the stored value.

Every state change happens on the single clock, and only in cycles where the clock enable is high. This includes the synchronizer stages.

Top module: `gpio_indirect`

## Requirements
- R1: While reset is asserted, and after it is released, the index is 0 and every data and direction bit is 0. As a result, every output-enable bit is 1, every pin output is 0, and a read at select 0 returns 0.
- R2: A write with select 0 stores all 8 bits of the write data in the index register. A read with select 0 returns the stored index.
- R3: The index keeps its value across any number of data-window accesses. Repeated select-1 writes and reads all reach the same internal register.
- R4: Index 0 selects the narrow data register and index 1 selects the narrow direction register. Index 2 selects the wide data register and index 3 selects the wide direction register. A direction register reads back its stored value.
- R5: Each pin's output-enable bit is the complement of its direction bit. Direction 0 means output and drives the pin. Direction 1 means input and does not drive it.
- R6: A data-register write updates the pin outputs of that group on the next clock edge.
- R7: A data-register read returns the synchronized pin level in bit positions whose direction is 1. It returns the stored data bit in positions whose direction is 0.
- R8: A pin change becomes visible on reads after exactly two clock edges that have the clock enable high. It is not visible after one such edge.
- R9: When a direction bit changes from 1 to 0, the pin starts driving the most recently written data bit. This happens on the same edge that stores the new direction.
- R10: When the clock enable is low, writes are ignored and the synchronizer does not advance.
- R11: Reads of the narrow registers return 0 in bits 7:3. A write to a narrow register keeps only bits 2:0.
- R12: Index values of 4 and above read as 0 through the data window. Writes made through the data window at those index values change no pin output, no output enable and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable; state changes only when high |
| sel | input | 1 | 0 selects the index register, 1 selects the data window |
| wr_en | input | 1 | Write strobe, qualified by ce |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the location chosen by sel (combinational) |
| na_in | input | 3 | Narrow group pin levels |
| na_out | output | 3 | Narrow group drive values |
| na_oe | output | 3 | Narrow group output enables (1 = drive) |
| wb_in | input | 8 | Wide group pin levels |
| wb_out | output | 8 | Wide group drive values |
| wb_oe | output | 8 | Wide group output enables (1 = drive) |

## Verification
The bench targets the following corner cases:
- Mixed readback with a split direction mask. A design that swapped the two sources would return stored bits where it should return pin levels.
- The two-edge synchronizer delay. A missing stage would show a pin change one edge early, and an extra stage one edge late.
- Writes made while the clock enable is low, and writes at out-of-range indices. A wrong design would corrupt the pins.
- Bits 7:3 of the narrow registers. A wrong design would leak nonzero values there.
- Switching a pin from input to output. The pin must drive the stored data at once, not a stale or zero value.
- Index persistence. A design that cleared the index after a data access would send the second write to register 0.

A behavioural model, checked every cycle under random enable, select and pin traffic, covers the interactions between these cases.

// File: rtl/gpio_indirect.sv
`timescale 1ns/1ps
module gpio_indirect #(
  parameter int DW   = 8,
  parameter int NA_W = 3,
  parameter int NB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic            sel,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NA_W-1:0] na_in,
  output logic [NA_W-1:0] na_out,
  output logic [NA_W-1:0] na_oe,
  input  logic [NB_W-1:0] wb_in,
  output logic [NB_W-1:0] wb_out,
  output logic [NB_W-1:0] wb_oe
);
  localparam logic [DW-1:0] IX_NA_DAT = DW'(0);
  localparam logic [DW-1:0] IX_NA_DIR = DW'(1);
  localparam logic [DW-1:0] IX_WB_DAT = DW'(2);
  localparam logic [DW-1:0] IX_WB_DIR = DW'(3);

  logic [DW-1:0]   idx_q;
  logic [NA_W-1:0] na_dat, na_dir, na_s1, na_s2;
  logic [NB_W-1:0] wb_dat, wb_dir, wb_s1, wb_s2;

  logic wr_idx, wr_win;
  assign wr_idx = ce & wr_en & ~sel;
  assign wr_win = ce & wr_en & sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      na_dat <= '0;
      na_dir <= '0;
      wb_dat <= '0;
      wb_dir <= '0;
      na_s1  <= '0;
      na_s2  <= '0;
      wb_s1  <= '0;
      wb_s2  <= '0;
    end else if (ce) begin
      na_s1 <= na_in;
      na_s2 <= na_s1;
      wb_s1 <= wb_in;
      wb_s2 <= wb_s1;
      if (wr_idx) idx_q <= wdata;
      if (wr_win) begin
        case (idx_q)
          IX_NA_DAT: na_dat <= wdata[NA_W-1:0];
          IX_NA_DIR: na_dir <= wdata[NA_W-1:0];
          IX_WB_DAT: wb_dat <= wdata[NB_W-1:0];
          IX_WB_DIR: wb_dir <= wdata[NB_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign na_out = na_dat;
  assign wb_out = wb_dat;
  assign na_oe  = ~na_dir;
  assign wb_oe  = ~wb_dir;

  logic [NA_W-1:0] na_rb;
  logic [NB_W-1:0] wb_rb;
  assign na_rb = (na_s2 & na_dir) | (na_dat & ~na_dir);
  assign wb_rb = (wb_s2 & wb_dir) | (wb_dat & ~wb_dir);

  always_comb begin
    rdata = '0;
    if (!sel) rdata = idx_q;
    else begin
      case (idx_q)
        IX_NA_DAT: rdata[NA_W-1:0] = na_rb;
        IX_NA_DIR: rdata[NA_W-1:0] = na_dir;
        IX_WB_DAT: rdata[NB_W-1:0] = wb_rb;
        IX_WB_DIR: rdata[NB_W-1:0] = wb_dir;
        default: rdata = '0;
      endcase
    end
  end

  // R2
  idx_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx |=> idx_q == $past(wdata));

  // R6
  wb_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && idx_q == IX_WB_DAT) |=> wb_out == $past(wdata[NB_W-1:0]));

  // R5
  na_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && idx_q == IX_NA_DIR) |=> na_oe == ~$past(wdata[NA_W-1:0]));

  // R10
  ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(idx_q) && $stable(na_out) && $stable(wb_out) &&
             $stable(na_oe) && $stable(wb_oe) && $stable(wb_s2) && $stable(na_s2)));

  // R12
  oob_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && idx_q > IX_WB_DIR) |=> ($stable(na_out) && $stable(wb_out) &&
                                       $stable(na_oe) && $stable(wb_oe)));

  // R11
  narrow_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && (idx_q == IX_NA_DAT || idx_q == IX_NA_DIR)) |-> rdata[DW-1:NA_W] == '0);
endmodule

// File: tb/gpio_indirect_bench.sv
`timescale 1ns/1ps
module gpio_indirect_bench;
  logic clk = 0, rst_n = 0, ce = 0, sel = 0, wr_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic [2:0] na_in = 0, na_out, na_oe;
  logic [7:0] wb_in = 0, wb_out, wb_oe;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_indirect u_gpio_indirect (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sel(sel), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata),
    .na_in(na_in), .na_out(na_out), .na_oe(na_oe),
    .wb_in(wb_in), .wb_out(wb_out), .wb_oe(wb_oe));

  int m_idx, m_nd, m_nr, m_wd, m_wr, m_na1, m_na2, m_wb1, m_wb2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 0; m_nd = 0; m_nr = 0; m_wd = 0; m_wr = 0;
      m_na1 = 0; m_na2 = 0; m_wb1 = 0; m_wb2 = 0;
    end else if (ce) begin
      m_na2 = m_na1; m_na1 = int'(na_in);
      m_wb2 = m_wb1; m_wb1 = int'(wb_in);
      if (wr_en) begin
        if (!sel) m_idx = int'(wdata);
        else if (m_idx == 0) m_nd = int'(wdata) & 7;
        else if (m_idx == 1) m_nr = int'(wdata) & 7;
        else if (m_idx == 2) m_wd = int'(wdata);
        else if (m_idx == 3) m_wr = int'(wdata);
      end
    end
  end

  function automatic int exp_rd(bit s);
    if (!s) return m_idx;
    case (m_idx)
      0: return ((m_na2 & m_nr) | (m_nd & ~m_nr)) & 7;
      1: return m_nr;
      2: return ((m_wb2 & m_wr) | (m_wd & ~m_wr)) & 255;
      3: return m_wr;
      default: return 0;
    endcase
  endfunction

  task automatic cmp(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      cmp(int'(rdata), exp_rd(sel), "R7 model rdata");
      cmp(int'(na_out), m_nd, "R6 model na_out");
      cmp(int'(wb_out), m_wd, "R6 model wb_out");
      cmp(int'(na_oe), (~m_nr) & 7, "R5 model na_oe");
      cmp(int'(wb_oe), (~m_wr) & 255, "R5 model wb_oe");
    end
  end

  task automatic wr_reg(bit s, logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr_en = 1; ce = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(bit s, int exp, string tag);
    @(negedge clk); sel = s; #1 cmp(int'(rdata), exp, tag);
  endtask

  task automatic finish_up;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 during reset
    cmp(int'(wb_oe), 8'hFF, "R1 wb_oe in reset");
    cmp(int'(na_out), 0, "R1 na_out in reset");
    @(negedge clk); rst_n = 1; ce = 1;
    rd_chk(0, 0, "R1 index after reset");
    cmp(int'(na_oe), 7, "R1 na_oe after reset");
    cmp(int'(wb_out), 0, "R1 wb_out after reset");

    wr_reg(0, 8'h03);
    rd_chk(0, 3, "R2 index readback");
    wr_reg(0, 8'hC7);
    rd_chk(0, 8'hC7, "R2 full-width index");
    wr_reg(0, 8'h03);
    wr_reg(1, 8'hF0);
    #1 cmp(int'(wb_oe), 8'h0F, "R5 wb_oe after dir write");
    rd_chk(1, 8'hF0, "R4 wide dir readback");
    wr_reg(0, 8'h02);
    @(negedge clk); wb_in = 8'h3C;
    wr_reg(1, 8'hA5);
    #1 cmp(int'(wb_out), 8'hA5, "R6 wb_out after data write");
    repeat (2) @(negedge clk);
    rd_chk(1, 8'h35, "R7 mixed readback");
    // R8 two-edge synchronizer
    @(negedge clk); wb_in = 8'hC0; #1 cmp(int'(rdata), 8'h35, "R8 before edges");
    @(negedge clk); #1 cmp(int'(rdata), 8'h35, "R8 after one edge");
    @(negedge clk); #1 cmp(int'(rdata), 8'hC5, "R8 after two edges");
    // R3 second data write, same index
    wr_reg(1, 8'h5A);
    #1 cmp(int'(wb_out), 8'h5A, "R3 index persists");
    rd_chk(1, 8'hCA, "R3 read same register");
    // R10 ce low
    @(negedge clk); ce = 0; sel = 1; wdata = 8'h11; wr_en = 1;
    @(negedge clk); sel = 0; wdata = 8'h01;
    @(negedge clk); wb_in = 8'h00;
    @(negedge clk); wr_en = 0; sel = 1; #1;
    cmp(int'(wb_out), 8'h5A, "R10 data write ignored");
    cmp(int'(rdata), 8'hCA, "R10 index and sync held");
    ce = 1;
    // R9 switch to output
    wr_reg(0, 8'h03);
    wr_reg(1, 8'h00);
    #1 cmp(int'(wb_out), 8'h5A, "R9 drives stored value");
    cmp(int'(wb_oe), 8'hFF, "R9 all enabled");
    // R11 narrow
    wr_reg(0, 8'h00);
    wr_reg(1, 8'hFF);
    #1 cmp(int'(na_out), 7, "R11 narrow stores low bits");
    rd_chk(1, 7, "R11 narrow upper bits zero");
    wr_reg(0, 8'h01);
    wr_reg(1, 8'hFD);
    #1 cmp(int'(na_oe), 3'b010, "R4 narrow dir reg1");
    rd_chk(1, 5, "R4 narrow dir readback");
    // R12 out of range
    wr_reg(0, 8'h05);
    wr_reg(1, 8'h33);
    #1 cmp(int'(wb_out), 8'h5A, "R12 wb_out unchanged");
    cmp(int'(na_out), 7, "R12 na_out unchanged");
    cmp(int'(na_oe), 3'b010, "R12 na_oe unchanged");
    rd_chk(1, 0, "R12 reads zero");

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ce = ($urandom % 4) != 0;
      sel = ($urandom % 3) != 0;
      wr_en = $urandom % 2;
      wdata = (sel == 0) ? 8'($urandom % 6) : 8'($urandom);
      na_in = 3'($urandom);
      wb_in = 8'($urandom);
    end
    @(negedge clk); wr_en = 0;
    @(negedge clk);
    finish_up();
  end
endmodule